// File: doc/BRIEF.md
# Programmable Two-State Cell Pipeline

This block is a linear chain of one-bit state cells. Each cell keeps a single state bit. Its next state comes from a 4-bit transition code, looked up by the cell's current state and its one-bit input. With the right code, one cell can act as a plain delay, an inverting delay, a toggle on 1, a toggle on 0, or a gated oscillator. The first stage reads an external serial bit stream. Every later stage reads the state of the stage before it. Each state bit is driven out as a tap.

Software-side logic presents a code and an initial state for every stage, then pulses a load, or holds reset. Every cell captures its code and initial state at the same clock edge. After that, the chain advances one step on each rising edge while the enable input is high. A loop mode, chosen at load time, closes the chain into a ring: the last stage's state feeds stage 0, so the sequence depends only on the codes and the initial states.

Top module: `twostate_chain`

## Requirements
- R1: For each stage k, `cfgCodes[4k+3:4k]` is that stage's code. On a step, the new state for (state, input) = (0,0), (0,1), (1,0), (1,1) is code bit 3, 2, 1, 0 respectively. All 16 codes are legal.
- R2: On a rising edge where `rstN` is low or `loadCfg` is high, each stage k takes `cfgInit[k]` as its state and latches its code. The taps show the new states after that edge.
- R3: A load takes priority over `enable`. On a load edge no step happens, whatever value `enable` has.
- R4: On an edge with no load and `enable` low, every tap keeps its value.
- R5: On a step, stage k>0 uses as its input the value that tap k−1 held before the edge. A bit moves at most one stage per clock.
- R6: With loop mode off, stage 0 uses `serialIn` as its input on a step.
- R7: Loop mode is the value of `loopSel` captured on a load edge. With loop mode on, stage 0 uses the previous value of tap N−1 as its input, and `serialIn` has no effect on the taps.
- R8: Changes of `loopSel` between loads have no effect on the taps.
- R9: A delay stage (code 0101) fed 1,0,1,0,… and followed by a toggle-on-1 stage (code 0110) that starts at 0 makes the second tap a square wave of period 4 cycles.
- R10: A toggle-on-1 stage (code 0110) that starts at 0 and is fed the repeating input 1,0,1,0,0,0,0,0 shows tap values 0,1,1,0,0,0,0,0 repeating, counted from the load.
- R11: Changes of `cfgCodes` and `cfgInit` between loads have no effect on the taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset; acts like a load |
| loadCfg | input | 1 | Synchronous load of codes, initial states and loop mode |
| enable | input | 1 | Advance all stages one step |
| loopSel | input | 1 | Loop-mode request, captured on load |
| serialIn | input | 1 | External input bit for stage 0 |
| cfgCodes | input | 4*NUM_STAGES | Per-stage transition codes, stage k in bits 4k+3:4k |
| cfgInit | input | NUM_STAGES | Per-stage initial state |
| taps | output | NUM_STAGES | State bit of every stage |

## Verification
A corrupted state bit or latched code shows up on that stage's tap at the next step. One cycle later it shows on each stage after it, one stage per cycle. So an internal fault reaches the last tap within N steps, unless a code masks it (for example, a constant-output code). A wrongly captured loop mode shows as soon as `serialIn` and the last tap disagree on a step. The bench compares every tap against a behavioural reference on every clock. It runs the stages through all 16 codes under random input, and checks the divide-by-two and 10100000 patterns explicitly.

// File: rtl/cellpipe_pkg.sv
package cellpipe_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic load;      // capture codes, initial states and loop mode
    logic step;      // advance every stage once
    logic loopMode;  // stage 0 fed from last stage
  } chainCtrl_t;
endpackage

// File: rtl/state_cell.sv
module state_cell
  import cellpipe_pkg::*;
(
  input  logic              clk,
  input  chainCtrl_t        ctrl,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              initIn,
  input  logic              cellIn,
  output logic              stateOut
);
  logic [CODE_W-1:0] codeReg;
  logic              stateReg;
  logic              nextState;

  // Most significant code bit answers (state,input)=00, so index inverted.
  always_comb nextState = codeReg[{~stateReg, ~cellIn}];

  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      codeReg  <= codeIn;
      stateReg <= initIn;
    end else if (ctrl.step) begin
      stateReg <= nextState;
    end
  end

  assign stateOut = stateReg;
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import cellpipe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadCfg,
  input  logic       enable,
  input  logic       loopSel,
  output chainCtrl_t ctrl
);
  logic loopReg;
  logic loadNow;

  assign loadNow = ~rstN | loadCfg;

  always_ff @(posedge clk) begin
    if (loadNow) loopReg <= loopSel;
  end

  always_comb begin
    ctrl.load     = loadNow;
    ctrl.step     = enable & ~loadNow;
    ctrl.loopMode = loopReg;
  end
endmodule

// File: rtl/chain_datapath.sv
module chain_datapath
  import cellpipe_pkg::*;
#(
  parameter int NUM_STAGES = 8
) (
  input  logic                         clk,
  input  chainCtrl_t                   ctrl,
  input  logic                         serialIn,
  input  logic [NUM_STAGES*CODE_W-1:0] cfgCodes,
  input  logic [NUM_STAGES-1:0]        cfgInit,
  output logic [NUM_STAGES-1:0]        taps
);
  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] stageIn;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stageIn[k] = ctrl.loopMode ? taps[LAST] : serialIn;
    end else begin : g_body
      assign stageIn[k] = taps[k-1];
    end

    state_cell u_cell (
      .clk      (clk),
      .ctrl     (ctrl),
      .codeIn   (cfgCodes[k*CODE_W +: CODE_W]),
      .initIn   (cfgInit[k]),
      .cellIn   (stageIn[k]),
      .stateOut (taps[k])
    );
  end
endmodule

// File: rtl/twostate_chain.sv
module twostate_chain
  import cellpipe_pkg::*;
#(
  parameter int NUM_STAGES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         loadCfg,
  input  logic                         enable,
  input  logic                         loopSel,
  input  logic                         serialIn,
  input  logic [NUM_STAGES*CODE_W-1:0] cfgCodes,
  input  logic [NUM_STAGES-1:0]        cfgInit,
  output logic [NUM_STAGES-1:0]        taps
);
  chainCtrl_t ctrl;

  chain_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadCfg (loadCfg),
    .enable  (enable),
    .loopSel (loopSel),
    .ctrl    (ctrl)
  );

  chain_datapath #(.NUM_STAGES(NUM_STAGES)) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .serialIn (serialIn),
    .cfgCodes (cfgCodes),
    .cfgInit  (cfgInit),
    .taps     (taps)
  );
endmodule

// File: rtl/twostate_chain_chk.sv
module twostate_chain_chk
  import cellpipe_pkg::*;
#(
  parameter int NUM_STAGES = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         loadCfg,
  input logic                         enable,
  input logic                         loopSel,
  input logic                         serialIn,
  input logic [NUM_STAGES*CODE_W-1:0] cfgCodes,
  input logic [NUM_STAGES-1:0]        cfgInit,
  input logic [NUM_STAGES-1:0]        taps
);
  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES*CODE_W-1:0] shCode;
  logic                         shLoop;
  logic [NUM_STAGES-1:0]        predNext;
  logic                         loopHead;

  always_ff @(posedge clk) begin
    if (!rstN || loadCfg) begin
      shCode <= cfgCodes;
      shLoop <= loopSel;
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_STAGES; k++) begin
      logic inBit;
      inBit = (k == 0) ? (shLoop ? taps[LAST] : serialIn) : taps[(k == 0) ? 0 : k-1];
      predNext[k] = shCode[k*CODE_W + 3 - {30'd0, taps[k], inBit}];
    end
    loopHead = shCode[3 - {30'd0, taps[0], taps[LAST]}];
  end

  // R2: a load edge places the initial states on the taps
  a_r2_load_init: assert property (@(posedge clk) disable iff (!rstN)
    loadCfg |=> taps == $past(cfgInit));

  // R3: load wins over enable
  a_r3_load_priority: assert property (@(posedge clk) disable iff (!rstN)
    (loadCfg && enable) |=> taps == $past(cfgInit));

  // R4: no step without enable
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loadCfg && !enable) |=> $stable(taps));

  // R5: every stage follows its latched code with the previous-tap input
  a_r5_chain_step: assert property (@(posedge clk) disable iff (!rstN)
    (!loadCfg && enable) |=> taps == $past(predNext));

  // R7: in loop mode stage 0 follows the last tap, not the serial input
  a_r7_loop_head: assert property (@(posedge clk) disable iff (!rstN)
    (!loadCfg && enable && shLoop) |=> taps[0] == $past(loopHead));
endmodule

bind twostate_chain twostate_chain_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (.*);

// File: tb/twostate_chain_tb.sv
module twostate_chain_tb;
  localparam int N = 8;
  localparam int CLK_HALF = 10;  // 50 MHz

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadCfg = 1'b0;
  logic         enable = 1'b0;
  logic         loopSel = 1'b0;
  logic         serialIn = 1'b0;
  logic [N*4-1:0] cfgCodes = '0;
  logic [N-1:0] cfgInit = '0;
  logic [N-1:0] taps;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  int mState[N];
  int mCode[N];
  int mLoop;

  always #(CLK_HALF) clk = ~clk;

  twostate_chain #(.NUM_STAGES(N)) u_dut (
    .clk(clk), .rstN(rstN), .loadCfg(loadCfg), .enable(enable),
    .loopSel(loopSel), .serialIn(serialIn), .cfgCodes(cfgCodes),
    .cfgInit(cfgInit), .taps(taps)
  );

  function automatic logic [N-1:0] modelVec();
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = mState[k][0];
    return v;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: taps=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: bit=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs (called just after a falling edge), advance model, compare.
  task automatic cyc(input bit ld, input bit en, input bit sin, input string req);
    int nxt[N];
    loadCfg = ld; enable = en; serialIn = sin;
    if (!rstN || ld) begin
      for (int k = 0; k < N; k++) begin
        nxt[k]  = int'(cfgInit[k]);
        mCode[k] = int'(cfgCodes[k*4 +: 4]);
      end
      mLoop = int'(loopSel);
    end else if (en) begin
      for (int k = 0; k < N; k++) begin
        int inB;
        if (k == 0) inB = mLoop ? mState[N-1] : int'(sin);
        else        inB = mState[k-1];
        nxt[k] = (mCode[k] >> (3 - (mState[k]*2 + inB))) & 1;
      end
    end else begin
      for (int k = 0; k < N; k++) nxt[k] = mState[k];
    end
    for (int k = 0; k < N; k++) mState[k] = nxt[k];
    @(negedge clk);
    check(req, taps, modelVec());
  endtask

  function automatic logic [N*4-1:0] codesOf(input int c[N]);
    logic [N*4-1:0] v;
    for (int k = 0; k < N; k++) v[k*4 +: 4] = c[k][3:0];
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    int codes[N];
    logic hist[$];

    // R2: reset acts as a load
    for (int k = 0; k < N; k++) codes[k] = k;
    cfgCodes = codesOf(codes);
    cfgInit  = 8'b1011_0010;
    @(negedge clk);
    cyc(0, 1, 1, "R2 reset");
    cyc(0, 1, 0, "R2 reset");
    rstN = 1'b1;
    check("R2 reset value", taps, 8'b1011_0010);

    // R1/R5/R6: all 16 codes across two configurations, random input
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < N; k++) codes[k] = pass*8 + k;
      cfgCodes = codesOf(codes);
      cfgInit  = 8'($urandom);
      loopSel  = 1'b0;
      cyc(1, 0, 0, "R2 load");
      for (int t = 0; t < 40; t++) cyc(0, 1, 1'($urandom), "R1 R5 R6 code sweep");
    end

    // R4: enable low holds taps
    for (int t = 0; t < 6; t++) cyc(0, 0, 1'($urandom), "R4 hold");

    // R3: load with enable high
    cfgInit = 8'b0101_1100;
    cyc(1, 1, 1, "R3 load priority");
    check("R3 load value", taps, 8'b0101_1100);

    // R9: delay then toggle-on-1, fed 1,0,1,0...
    for (int k = 0; k < N; k++) codes[k] = 4'b0101;
    codes[0] = 4'b0101; codes[1] = 4'b0110;
    cfgCodes = codesOf(codes);
    cfgInit  = '0;
    cyc(1, 0, 0, "R9 load");
    hist.delete();
    hist.push_back(taps[1]);
    for (int t = 0; t < 16; t++) begin
      cyc(0, 1, (t % 2 == 0), "R9 divide-by-two");
      hist.push_back(taps[1]);
    end
    for (int j = 2; j < hist.size(); j++)
      checkBit("R9 period-4 square wave", hist[j], ~hist[j-2]);

    // R10: toggle-on-1 at 0 fed 10100000
    codes[0] = 4'b0110;
    cfgCodes = codesOf(codes);
    cfgInit  = '0;
    cyc(1, 0, 0, "R10 load");
    checkBit("R10 pattern", taps[0], 1'b0);
    for (int t = 0; t < 32; t++) begin
      bit pin;
      bit expB;
      pin  = (t % 8 == 0) || (t % 8 == 2);
      cyc(0, 1, pin, "R10 pattern model");
      expB = ((t + 1) % 8 == 1) || ((t + 1) % 8 == 2);
      checkBit("R10 pattern", taps[0], expB);
    end

    // R7/R8/R11: ring of delays in loop mode
    for (int k = 0; k < N; k++) codes[k] = 4'b0101;
    cfgCodes = codesOf(codes);
    cfgInit  = 8'b0000_0001;
    loopSel  = 1'b1;
    cyc(1, 0, 0, "R7 load");
    for (int t = 0; t < 20; t++) cyc(0, 1, 1'($urandom), "R7 loop ignores serialIn");
    loopSel = 1'b0;
    for (int t = 0; t < 12; t++) cyc(0, 1, 1'($urandom), "R8 loopSel ignored");
    cfgCodes = '1;
    cfgInit  = 8'hA5;
    for (int t = 0; t < 12; t++) cyc(0, 1, 1'($urandom), "R11 config ignored");

    // Loop mode with mixed codes, then leave loop via a load
    for (int k = 0; k < N; k++) codes[k] = (k % 2 == 0) ? 4'b1010 : 4'b0110;
    cfgCodes = codesOf(codes);
    cfgInit  = 8'b1100_1010;
    loopSel  = 1'b1;
    cyc(1, 0, 0, "R7 load");
    for (int t = 0; t < 24; t++) cyc(0, (t % 5 != 0), 1'($urandom), "R7 R4 loop mixed");
    loopSel = 1'b0;
    cyc(1, 0, 0, "R6 load open");
    for (int t = 0; t < 24; t++) cyc(0, 1, 1'($urandom), "R6 open chain");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule